// File: doc/BRIEF.md
# Supervisory Reset and Watchdog Controller

This block produces the system reset for a chip from three sources. The first is a supply-fail flag from an external comparator. The second is a push-button style manual reset that is active low. The third is a watchdog that firmware must service by toggling a kick pin. Any active source asserts reset. Once every source has gone quiet, reset stays asserted for one shared timeout and then releases. A fresh source during that timeout starts the timeout over.

All timings are counted in clock cycles of a free-running clock:

- The reset stretch is `RST_CYCLES`, nominally about 210 ms.
- The watchdog interval is `WD_CYCLES`, nominally about 1.76 s.
- The manual-reset glitch filter length is `MR_FILT_CYCLES`. Its default at 125 MHz rejects pulses far shorter than 1 µs and responds well within half a microsecond.

Both edges of the kick pin service the watchdog. A separate enable flag marks the kick pin as undriven, and while that flag is low the watchdog is switched off. The supply flag also serves as the block's own asynchronous clear, so reset is asserted the moment the supply drops, even before any clock edge. The block drives the reset level on two pins: one active low and one active high.

Top module: `supv_reset_ctrl`

## Requirements
- R1: A low on `manRstN` lasting at least `MR_FILT_CYCLES` clock cycles asserts reset on the `MR_FILT_CYCLES+3`rd rising edge after the input falls. A low lasting `MR_FILT_CYCLES-1` cycles or less leaves reset deasserted.
- R2: After `manRstN` returns high with no other cause active, reset stays asserted and falls on the `RST_CYCLES+3`rd rising edge after the input rises.
- R3: Any change of `wdKick`, rising or falling, restarts the watchdog interval. A kick whose effect lands in the final cycle of the interval still prevents the expiry, and the next expiry then occurs `WD_CYCLES+3` edges after that kick.
- R4: With the watchdog enabled and `wdKick` steady, reset asserts exactly `WD_CYCLES` cycles after it was last released. A kick arriving one cycle too late does not prevent it.
- R5: A watchdog expiry holds reset for exactly `RST_CYCLES` cycles. The watchdog stays cleared while reset is asserted, so the following interval is again a full `WD_CYCLES`.
- R6: While `wdEnable` is low the watchdog never expires. When it is raised, expiry follows after `WD_CYCLES` cycles of a steady kick pin.
- R7: A low on `powerGood` asserts reset at once, without a clock edge. After it rises, reset falls on the `RST_CYCLES+2`nd rising edge.
- R8: A cause that appears while the timeout is running reloads the timeout. Reset releases only after `RST_CYCLES` cycles with no cause active.
- R9: `rstOutN` is always the complement of `rstOut`, where `rstOut` high means reset is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| powerGood | input | 1 | Supply-good flag from the comparator; low clears the block asynchronously and forces reset |
| manRstN | input | 1 | Manual reset request, active low, asynchronous |
| wdKick | input | 1 | Watchdog service pin; every edge restarts the interval |
| wdEnable | input | 1 | High when the kick pin is driven; low disables the watchdog |
| rstOutN | output | 1 | System reset, active low |
| rstOut | output | 1 | System reset, active high |

## Verification
Two watchdog events can coincide in one cycle: a kick edge reaching the counter, and the counter reaching its last count. The bench releases reset and then toggles the kick pin at two chosen points. The first is placed so that, after the three synchronizing flops, the detected edge falls exactly in the expiry cycle. The second is one cycle later. The bench judges the outcome by when reset next rises. In the first case reset should rise a full interval plus three edges after the kick. In the second case it should rise two edges after the kick.

// File: rtl/supv_pkg.sv
package supv_pkg;

  // Conditions reported by the datapath to the control
  typedef struct packed {
    logic pgOk;      // synchronized supply-good
    logic mrQual;    // manual reset held low long enough
    logic wdExpire;  // watchdog reached its last count with no kick
    logic kickEdge;  // an edge of the kick pin was detected
    logic toDone;    // quiet timeout has run to its end
  } supv_stat_t;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic toReload;  // restart the quiet timeout
    logic wdClear;   // clear the watchdog counter
  } supv_strb_t;

endpackage

// File: rtl/supv_sync.sv
module supv_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic arstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/supv_datapath.sv
module supv_datapath import supv_pkg::*; #(
  parameter int RST_CYCLES     = 26_250_000,
  parameter int WD_CYCLES      = 220_000_000,
  parameter int MR_FILT_CYCLES = 32
) (
  input  logic       clk,
  input  logic       powerGood,
  input  logic       manRstN,
  input  logic       wdKick,
  input  supv_strb_t strb,
  output supv_stat_t stat
);
  localparam int TO_W = $clog2(RST_CYCLES + 1);
  localparam int WD_W = $clog2(WD_CYCLES + 1);
  localparam int MR_W = $clog2(MR_FILT_CYCLES + 1);
  localparam logic [TO_W-1:0] TO_LAST = TO_W'(RST_CYCLES - 1);
  localparam logic [WD_W-1:0] WD_LAST = WD_W'(WD_CYCLES - 1);
  localparam logic [MR_W-1:0] MR_FULL = MR_W'(MR_FILT_CYCLES);

  logic pgSync, mrSync, kickSync, kickLast;
  logic [MR_W-1:0] mrLowCnt;
  logic [WD_W-1:0] wdCnt;
  logic [TO_W-1:0] toCnt;

  // Reset synchronizer for the supply flag: asserts at once, releases after two edges
  supv_sync #(.STAGES(2), .RST_VAL(1'b0)) uPgSync (
    .clk(clk), .arstN(powerGood), .d(1'b1), .q(pgSync));

  supv_sync #(.STAGES(2), .RST_VAL(1'b1)) uMrSync (
    .clk(clk), .arstN(powerGood), .d(manRstN), .q(mrSync));

  supv_sync #(.STAGES(2), .RST_VAL(1'b0)) uKickSync (
    .clk(clk), .arstN(powerGood), .d(wdKick), .q(kickSync));

  always_ff @(posedge clk or negedge powerGood) begin
    if (!powerGood) begin
      kickLast <= 1'b0;
      mrLowCnt <= '0;
      wdCnt    <= '0;
      toCnt    <= '0;
    end else begin
      kickLast <= kickSync;
      // Glitch filter: count consecutive low samples, saturate at the limit
      if (mrSync)                 mrLowCnt <= '0;
      else if (mrLowCnt != MR_FULL) mrLowCnt <= mrLowCnt + 1'b1;
      // Watchdog interval
      if (strb.wdClear) wdCnt <= '0;
      else              wdCnt <= wdCnt + 1'b1;
      // Quiet timeout, saturating at its last count
      if (strb.toReload)        toCnt <= '0;
      else if (toCnt != TO_LAST) toCnt <= toCnt + 1'b1;
    end
  end

  always_comb begin
    stat.pgOk     = pgSync;
    stat.mrQual   = (mrLowCnt == MR_FULL);
    stat.kickEdge = kickSync ^ kickLast;
    stat.wdExpire = (wdCnt == WD_LAST) && !stat.kickEdge;
    stat.toDone   = (toCnt == TO_LAST);
  end
endmodule

// File: rtl/supv_control.sv
module supv_control import supv_pkg::*; (
  input  logic       clk,
  input  logic       powerGood,
  input  logic       wdEnable,
  input  supv_stat_t stat,
  output supv_strb_t strb,
  output logic       rstAct
);
  logic cause;

  always_comb begin
    cause         = !stat.pgOk || stat.mrQual || stat.wdExpire;
    strb.toReload = cause;
    // Watchdog is held cleared while reset is pending or active, or while disabled
    strb.wdClear  = rstAct || cause || !wdEnable || stat.kickEdge;
  end

  always_ff @(posedge clk or negedge powerGood) begin
    if (!powerGood)       rstAct <= 1'b1;
    else if (cause)       rstAct <= 1'b1;
    else if (stat.toDone) rstAct <= 1'b0;
  end
endmodule

// File: rtl/supv_reset_ctrl.sv
module supv_reset_ctrl import supv_pkg::*; #(
  parameter int RST_CYCLES     = 26_250_000,
  parameter int WD_CYCLES      = 220_000_000,
  parameter int MR_FILT_CYCLES = 32
) (
  input  logic clk,
  input  logic powerGood,
  input  logic manRstN,
  input  logic wdKick,
  input  logic wdEnable,
  output logic rstOutN,
  output logic rstOut
);
  supv_stat_t stat;
  supv_strb_t strb;
  logic       rstAct;

  supv_datapath #(
    .RST_CYCLES(RST_CYCLES), .WD_CYCLES(WD_CYCLES), .MR_FILT_CYCLES(MR_FILT_CYCLES)
  ) uDatapath (
    .clk(clk), .powerGood(powerGood), .manRstN(manRstN), .wdKick(wdKick),
    .strb(strb), .stat(stat));

  supv_control uControl (
    .clk(clk), .powerGood(powerGood), .wdEnable(wdEnable),
    .stat(stat), .strb(strb), .rstAct(rstAct));

  assign rstOut  = rstAct;
  assign rstOutN = ~rstAct;
endmodule

// File: rtl/supv_reset_checker.sv
module supv_reset_checker import supv_pkg::*; (
  input logic       clk,
  input logic       powerGood,
  input logic       wdEnable,
  input logic       rstOut,
  input supv_stat_t stat
);
  AST_MR_FORCES: assert property (@(posedge clk) disable iff (!powerGood)
    stat.mrQual |=> rstOut); // R1
  AST_RELEASE_AFTER_TIMEOUT: assert property (@(posedge clk) disable iff (!powerGood)
    $fell(rstOut) |-> $past(stat.toDone)); // R2
  AST_KICK_RESTARTS: assert property (@(posedge clk) disable iff (!powerGood)
    stat.kickEdge |=> !stat.wdExpire); // R3
  AST_EXPIRY_RESETS: assert property (@(posedge clk) disable iff (!powerGood)
    stat.wdExpire |=> rstOut); // R4
  AST_HELD_IN_RESET: assert property (@(posedge clk) disable iff (!powerGood)
    rstOut |=> !stat.wdExpire); // R5
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!powerGood)
    !wdEnable |=> !stat.wdExpire); // R6
  AST_SUPPLY_HOLDS: assert property (@(posedge clk) disable iff (!powerGood)
    !stat.pgOk |=> rstOut); // R7
  AST_NO_EARLY_RELEASE: assert property (@(posedge clk) disable iff (!powerGood)
    (rstOut && stat.mrQual) |=> rstOut); // R8
endmodule

bind supv_reset_ctrl supv_reset_checker uChecker (
  .clk(clk), .powerGood(powerGood), .wdEnable(wdEnable),
  .rstOut(rstOut), .stat(stat));

// File: tb/supv_reset_ctrl_test.sv
module supv_reset_ctrl_test;
  localparam int RST  = 40;
  localparam int WD   = 60;
  localparam int FILT = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic powerGood = 1'b1, manRstN = 1'b1, wdKick = 1'b0, wdEnable = 1'b0;
  logic rstOutN, rstOut;
  int   vectors = 0, misses = 0;
  bit   finished = 1'b0;

  supv_reset_ctrl #(.RST_CYCLES(RST), .WD_CYCLES(WD), .MR_FILT_CYCLES(FILT)) uut (
    .clk(clk), .powerGood(powerGood), .manRstN(manRstN), .wdKick(wdKick),
    .wdEnable(wdEnable), .rstOutN(rstOutN), .rstOut(rstOut));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic compCheck();
    check(rstOutN === ~rstOut, "R9", int'(rstOutN), int'(~rstOut));
  endtask

  // Count falling clock edges until rstOut reaches lvl
  task automatic countUntil(input logic lvl, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
      compCheck();
    end while (rstOut !== lvl && n < 10000);
  endtask

  // rstOut must hold lvl for the given number of cycles
  task automatic stayLevel(input logic lvl, input int cycles, input string req);
    int bad = 0;
    repeat (cycles) begin
      @(negedge clk);
      if (rstOut !== lvl) bad++;
    end
    check(bad == 0, req, bad, 0);
  endtask

  task automatic tPowerUp();
    int n;
    #2 powerGood = 1'b0;
    #1;
    check(rstOut === 1'b1, "R7", int'(rstOut), 1);
    check(rstOutN === 1'b0, "R9", int'(rstOutN), 0);
    repeat (3) @(negedge clk);
    powerGood = 1'b1;
    countUntil(1'b0, n);
    check(n == RST + 2, "R7", n, RST + 2);
  endtask

  task automatic tMrGlitch();
    @(negedge clk);
    manRstN = 1'b0;
    repeat (FILT - 1) @(negedge clk);
    manRstN = 1'b1;
    stayLevel(1'b0, 20, "R1");
  endtask

  task automatic tMrPress();
    int n;
    manRstN = 1'b0;
    countUntil(1'b1, n);
    check(n == FILT + 3, "R1", n, FILT + 3);
    repeat (5) @(negedge clk);
    manRstN = 1'b1;
    countUntil(1'b0, n);
    check(n == RST + 3, "R2", n, RST + 3);
  endtask

  task automatic tReload();
    int n;
    manRstN = 1'b0;
    countUntil(1'b1, n);
    repeat (3) @(negedge clk);
    manRstN = 1'b1;
    stayLevel(1'b1, RST / 2, "R8");
    manRstN = 1'b0;
    stayLevel(1'b1, FILT + 4, "R8");
    manRstN = 1'b1;
    countUntil(1'b0, n);
    check(n == RST + 3, "R8", n, RST + 3);
  endtask

  task automatic tWdExpire();
    int n;
    wdEnable = 1'b1;
    countUntil(1'b1, n);
    check(n == WD, "R4", n, WD);
    countUntil(1'b0, n);
    check(n == RST, "R5", n, RST);
    countUntil(1'b1, n);
    check(n == WD, "R5", n, WD);
    wdEnable = 1'b0;
    countUntil(1'b0, n);
    check(n == RST, "R5", n, RST);
  endtask

  task automatic tWdDisable();
    int n;
    stayLevel(1'b0, 3 * WD, "R6");
    wdEnable = 1'b1;
    countUntil(1'b1, n);
    check(n == WD, "R6", n, WD);
    countUntil(1'b0, n);
  endtask

  task automatic tKick();
    int n;
    // Alternate edges keep the watchdog quiet
    for (int i = 0; i < 6; i++) begin
      stayLevel(1'b0, WD - 8, "R3");
      wdKick = ~wdKick;
    end
    countUntil(1'b1, n);
    check(n == WD + 3, "R3", n, WD + 3);
    countUntil(1'b0, n);
    // Kick whose edge lands in the expiry cycle
    repeat (WD - 3) @(negedge clk);
    wdKick = ~wdKick;
    countUntil(1'b1, n);
    check(n == WD + 3, "R3", n, WD + 3);
    countUntil(1'b0, n);
    // Kick one cycle too late
    repeat (WD - 2) @(negedge clk);
    wdKick = ~wdKick;
    countUntil(1'b1, n);
    check(n == 2, "R4", n, 2);
    countUntil(1'b0, n);
    wdEnable = 1'b0;
  endtask

  task automatic tPowerDrop();
    int n;
    repeat (5) @(negedge clk);
    #1 powerGood = 1'b0;
    #1;
    check(rstOut === 1'b1, "R7", int'(rstOut), 1);
    compCheck();
    repeat (3) @(negedge clk);
    powerGood = 1'b1;
    countUntil(1'b0, n);
    check(n == RST + 2, "R7", n, RST + 2);
  endtask

  initial begin
    tPowerUp();
    tMrGlitch();
    tMrPress();
    tReload();
    tWdExpire();
    tWdDisable();
    tKick();
    tPowerDrop();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      vectors++;
      misses++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule